// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

The block puts a small register window in front of a word-organised flash array model. Software loads a target byte address and a data word into two registers. It then writes a command word to a third register. The command is honoured only when its upper half carries an unlock key. A keyed command starts one of two operations. The first programs a single 32-bit word. The second erases a 1 KB page. Each operation's command bit then serves as its busy flag, and software polls that flag until it drops to zero.

Programming ANDs the new data into the stored word, so a program can only clear bits. Erase returns every word of the selected page to all-ones. Each operation's length is set by a parameter, which keeps the busy window long enough to observe through polling. A separate read port returns any array word. This port is how the array's contents become visible.

Top module: `kfc_top`

## Requirements
- R1: The register window decodes byte offsets 0x0 (target address), 0x4 (data word) and 0x8 (command/status). Offset 0x0 reads back the written value with every bit at or above log2(array bytes) cleared (0xFFF mask by default). Offset 0x4 reads back all 32 bits. Offset 0xC ignores writes and reads as zero.
- R2: A write to offset 0x8 is a command only if bits [31:16] equal 0xA442. With any other key the write changes neither the busy bits nor the array.
- R3: A keyed command with bit 0 set (program) replaces the word addressed by bits [log2(bytes)-1:2] of the target address with the old word AND the data register. Address bits [1:0] are ignored.
- R4: A keyed command with bit 1 set (erase) sets all 256 words of the 1 KB page containing the target address to 0xFFFFFFFF. Address bits [9:0] are ignored, and every other page is left unchanged.
- R5: Status bit 0 reads 1 for exactly PROG_CYCLES cycles (default 4), counted from the edge that accepts a program. Status bit 1 reads 1 for exactly max(ERASE_CYCLES, 256) cycles (default 256), counted from the edge that accepts an erase. Each bit then reads 0, and the program result is visible in the first cycle after bit 0 clears.
- R6: A command written while either operation is busy is ignored.
- R7: A keyed command with both bits 0 and 1 set performs an erase only. At most one busy bit is ever set.
- R8: While rst_n is low, all three registers read zero and the block is idle. After rst_n rises, writes take effect from the third rising clock edge onward.
- R9: An operation uses the address and data captured on its accepting edge. Register writes made while it is busy do not alter it.
- R10: fetch_data returns the array word selected by fetch_addr bits [log2(bytes)-1:2]. The higher bits and bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 4 | Byte offset within the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fetch_addr | input | 32 | Byte address for the array read port |
| fetch_data | output | 32 | Array word at fetch_addr, combinational |

## Verification
The assertions assume the write strobe, offset and data are stable across each rising edge. They also assume at most one register is written per cycle. The stimulus respects both by driving the bus on falling edges and issuing a single write per task call. The busy-length properties also assume that nothing restarts the sequencer except a keyed command. The bench probes this assumption by issuing commands inside busy windows and with wrong keys. The bench reads array contents only through the fetch port, and only after it has erased those words. Until then their values are undefined.

// File: rtl/kfc_pkg.sv
package kfc_pkg;

  localparam logic [15:0] KFC_KEY       = 16'hA442;
  localparam int          CMD_PROG_BIT  = 0;
  localparam int          CMD_ERASE_BIT = 1;

  // register select taken from byte offset bits [3:2]
  typedef enum logic [1:0] {
    OFS_ADDR = 2'd0,
    OFS_DATA = 2'd1,
    OFS_CMD  = 2'd2,
    OFS_RSVD = 2'd3
  } kfc_ofs_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PROG  = 2'd1,
    SEQ_ERASE = 2'd2
  } kfc_state_e;

endpackage

// File: rtl/kfc_regs.sv
module kfc_regs
  import kfc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_ofs,
  input  logic [31:0]       bus_wdata,
  input  logic              busy_prog,
  input  logic              busy_erase,
  output logic [ADDR_W-1:0] addr_q,
  output logic [31:0]       data_q,
  output logic              start_prog,
  output logic              start_erase,
  output logic [31:0]       bus_rdata
);

  logic [ADDR_W-1:0] addr_d;
  logic [31:0]       data_d;
  logic              addr_en;
  logic              data_en;
  logic              key_ok;
  logic              cmd_hit;
  logic              idle;
  kfc_ofs_e          ofs;

  assign ofs  = kfc_ofs_e'(bus_ofs);
  assign idle = !(busy_prog || busy_erase);

  // write decode and next values
  always_comb begin
    addr_en = bus_we && (ofs == OFS_ADDR);
    data_en = bus_we && (ofs == OFS_DATA);
    addr_d  = bus_wdata[ADDR_W-1:0];
    data_d  = bus_wdata;
  end

  // command qualification: key, idle, erase wins over program
  always_comb begin
    cmd_hit     = bus_we && (ofs == OFS_CMD);
    key_ok      = (bus_wdata[31:16] == KFC_KEY);
    start_erase = cmd_hit && key_ok && idle && bus_wdata[CMD_ERASE_BIT];
    start_prog  = cmd_hit && key_ok && idle && bus_wdata[CMD_PROG_BIT]
                  && !bus_wdata[CMD_ERASE_BIT];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (ofs)
      OFS_ADDR: bus_rdata[ADDR_W-1:0] = addr_q;
      OFS_DATA: bus_rdata             = data_q;
      OFS_CMD: begin
        bus_rdata[CMD_PROG_BIT]  = busy_prog;
        bus_rdata[CMD_ERASE_BIT] = busy_erase;
      end
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kfc_seq.sv
module kfc_seq
  import kfc_pkg::*;
#(
  parameter int WIDX_W      = 10,
  parameter int PIDX_W      = 8,
  parameter int PROG_CYCLES = 4,
  parameter int ERASE_LEN   = 256
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [WIDX_W-1:0] addr_widx,
  input  logic [31:0]       data_in,
  output logic              busy_prog,
  output logic              busy_erase,
  output logic              mem_we,
  output logic              mem_erase,
  output logic [WIDX_W-1:0] mem_widx,
  output logic [31:0]       mem_wdata
);

  localparam int LONGEST    = (ERASE_LEN > PROG_CYCLES) ? ERASE_LEN : PROG_CYCLES;
  localparam int CNT_W      = $clog2(LONGEST) + 1;
  localparam int PAGE_WORDS = 1 << PIDX_W;
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_LEN - 1);
  localparam logic [CNT_W-1:0] SWEEP_END  = CNT_W'(PAGE_WORDS);

  kfc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WIDX_W-1:0] op_widx_q;
  logic [31:0]       op_data_q;
  logic              op_en;
  logic              prog_last;
  logic              erase_last;

  assign prog_last  = (cnt_q == PROG_LAST);
  assign erase_last = (cnt_q == ERASE_LAST);
  assign op_en      = (state_q == SEQ_IDLE) && (start_prog || start_erase);

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (start_erase) begin
          state_d = SEQ_ERASE;
        end else if (start_prog) begin
          state_d = SEQ_PROG;
        end
      end
      SEQ_PROG: begin
        if (prog_last) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_ERASE: begin
        if (erase_last) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // operand capture on the accepting edge only
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      op_widx_q <= '0;
      op_data_q <= '0;
    end else if (op_en) begin
      op_widx_q <= addr_widx;
      op_data_q <= data_in;
    end
  end

  assign busy_prog  = (state_q == SEQ_PROG);
  assign busy_erase = (state_q == SEQ_ERASE);
  assign mem_erase  = busy_erase;
  assign mem_wdata  = op_data_q;
  assign mem_we     = (busy_prog && prog_last) || (busy_erase && (cnt_q < SWEEP_END));

  // erase sweeps the page one word per cycle
  generate
    if (WIDX_W > PIDX_W) begin : g_multi_page
      assign mem_widx = busy_erase ? {op_widx_q[WIDX_W-1:PIDX_W], cnt_q[PIDX_W-1:0]}
                                   : op_widx_q;
    end else begin : g_single_page
      assign mem_widx = busy_erase ? cnt_q[WIDX_W-1:0] : op_widx_q;
    end
  endgenerate

endmodule

// File: rtl/kfc_array.sv
module kfc_array #(
  parameter int WORDS  = 1024,
  parameter int WIDX_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic              erase,
  input  logic [WIDX_W-1:0] widx,
  input  logic [31:0]       wdata,
  input  logic [WIDX_W-1:0] ridx,
  output logic [31:0]       rdata
);

  logic [31:0] mem_q [WORDS];
  logic [31:0] word_d;

  // erase drives ones; program can only clear bits
  always_comb begin
    if (erase) begin
      word_d = '1;
    end else begin
      word_d = mem_q[widx] & wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[widx] <= word_d;
    end
  end

  assign rdata = mem_q[ridx];

endmodule

// File: rtl/kfc_top.sv
module kfc_top
  import kfc_pkg::*;
#(
  parameter int ARRAY_BYTES  = 4096,
  parameter int PAGE_BYTES   = 1024,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] fetch_addr,
  output logic [31:0] fetch_data
);

  localparam int ADDR_W     = $clog2(ARRAY_BYTES);
  localparam int WIDX_W     = ADDR_W - 2;
  localparam int WORDS      = ARRAY_BYTES / 4;
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int PIDX_W     = $clog2(PAGE_WORDS);
  localparam int ERASE_LEN  = (ERASE_CYCLES > PAGE_WORDS) ? ERASE_CYCLES : PAGE_WORDS;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic              start_prog;
  logic              start_erase;
  logic              busy_prog;
  logic              busy_erase;
  logic              mem_we;
  logic              mem_erase;
  logic [WIDX_W-1:0] mem_widx;
  logic [31:0]       mem_wdata;
  logic              unused_bits;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign unused_bits = ^{reg_addr[1:0], fetch_addr[31:ADDR_W], fetch_addr[1:0], addr_q[1:0]};

  kfc_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .arst_n      (rst_sync_n),
    .bus_we      (reg_we),
    .bus_ofs     (reg_addr[3:2]),
    .bus_wdata   (reg_wdata),
    .busy_prog   (busy_prog),
    .busy_erase  (busy_erase),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .bus_rdata   (reg_rdata)
  );

  kfc_seq #(
    .WIDX_W      (WIDX_W),
    .PIDX_W      (PIDX_W),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_LEN   (ERASE_LEN)
  ) u_seq (
    .clk         (clk),
    .arst_n      (rst_sync_n),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .addr_widx   (addr_q[ADDR_W-1:2]),
    .data_in     (data_q),
    .busy_prog   (busy_prog),
    .busy_erase  (busy_erase),
    .mem_we      (mem_we),
    .mem_erase   (mem_erase),
    .mem_widx    (mem_widx),
    .mem_wdata   (mem_wdata)
  );

  kfc_array #(
    .WORDS  (WORDS),
    .WIDX_W (WIDX_W)
  ) u_array (
    .clk   (clk),
    .we    (mem_we),
    .erase (mem_erase),
    .widx  (mem_widx),
    .wdata (mem_wdata),
    .ridx  (fetch_addr[ADDR_W-1:2]),
    .rdata (fetch_data)
  );

endmodule

// File: rtl/kfc_checker.sv
module kfc_checker
  import kfc_pkg::*;
#(
  parameter int PROG_CYCLES = 4,
  parameter int ERASE_LEN   = 256
) (
  input logic        clk,
  input logic        rst_ok,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy_prog,
  input logic        busy_erase
);

  logic [15:0] run_cnt;
  logic        idle;
  logic        cmd_hit;
  logic        keyed;

  assign idle    = !busy_prog && !busy_erase;
  assign cmd_hit = reg_we && (reg_addr[3:2] == 2'd2);
  assign keyed   = cmd_hit && (reg_wdata[31:16] == KFC_KEY);

  // cycles spent in the current operation
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      run_cnt <= '0;
    end else if (idle) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assert_one_op_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({busy_prog, busy_erase}));

  assert_prog_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy_prog && (run_cnt < 16'(PROG_CYCLES - 1))) |=> busy_prog);

  assert_prog_end_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy_prog && (run_cnt == 16'(PROG_CYCLES - 1))) |=> !busy_prog);

  assert_erase_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy_erase && (run_cnt < 16'(ERASE_LEN - 1))) |=> busy_erase);

  assert_erase_end_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy_erase && (run_cnt == 16'(ERASE_LEN - 1))) |=> !busy_erase);

  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (idle && cmd_hit && !keyed) |=> (!busy_prog && !busy_erase));

  assert_start_prog_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (idle && keyed && reg_wdata[0] && !reg_wdata[1]) |=> busy_prog);

  assert_erase_wins_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (idle && keyed && reg_wdata[1]) |=> (busy_erase && !busy_prog));

  assert_no_start_in_prog_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy_prog && cmd_hit) |=> !busy_erase);

  assert_no_start_in_erase_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy_erase && cmd_hit) |=> !busy_prog);

endmodule

bind kfc_top kfc_checker #(
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_LEN   (ERASE_LEN)
) u_kfc_checker (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .busy_prog  (busy_prog),
  .busy_erase (busy_erase)
);

// File: tb/sim_kfc_top.sv
`timescale 1ns/1ps
module sim_kfc_top;

  localparam int BYTES     = 4096;
  localparam int NWORDS    = BYTES / 4;
  localparam int PGWORDS   = 256;
  localparam int PROG_LEN  = 4;
  localparam int ERASE_LEN = 256;
  localparam logic [31:0] AMASK = 32'(BYTES - 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] fetch_addr = '0;
  logic [31:0] fetch_data;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R8";

  // behavioural reference state
  int          m_rs = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_data = '0;
  int          m_kind = 0;   // 0 idle, 1 program, 2 erase
  int          m_left = 0;
  int          m_widx = 0;
  logic [31:0] m_opd = '0;
  logic [31:0] m_mem [NWORDS];
  bit          m_known [NWORDS];

  always #2 clk = ~clk;

  kfc_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .fetch_addr (fetch_addr),
    .fetch_data (fetch_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_addr = '0; m_data = '0; m_kind = 0; m_left = 0;
    end else begin
      bit live;
      bit was_idle;
      live = (m_rs >= 2);
      if (m_rs < 2) m_rs++;
      if (live) begin
        was_idle = (m_kind == 0);
        if (!was_idle) begin
          m_left--;
          if (m_left == 0) begin
            if (m_kind == 1) begin
              m_mem[m_widx] = m_mem[m_widx] & m_opd;
            end else begin
              for (int i = 0; i < PGWORDS; i++) begin
                m_mem[(m_widx / PGWORDS) * PGWORDS + i] = 32'hFFFF_FFFF;
                m_known[(m_widx / PGWORDS) * PGWORDS + i] = 1'b1;
              end
            end
            m_kind = 0;
          end
        end
        if (reg_we) begin
          case (reg_addr[3:2])
            2'd0: m_addr = reg_wdata & AMASK;
            2'd1: m_data = reg_wdata;
            2'd2: if (was_idle && reg_wdata[31:16] == 16'hA442) begin
              if (reg_wdata[1]) begin
                m_kind = 2; m_left = ERASE_LEN; m_widx = int'(m_addr >> 2); m_opd = m_data;
              end else if (reg_wdata[0]) begin
                m_kind = 1; m_left = PROG_LEN; m_widx = int'(m_addr >> 2); m_opd = m_data;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // per-clock comparison, 1 ns after the edge
  always @(posedge clk) begin
    logic [31:0] exp;
    int fidx;
    #1;
    case (reg_addr[3:2])
      2'd0: exp = m_addr;
      2'd1: exp = m_data;
      2'd2: exp = {30'd0, m_kind == 2, m_kind == 1};
      default: exp = '0;
    endcase
    chk(cur_req, reg_rdata, exp);
    fidx = int'((fetch_addr & AMASK) >> 2);
    if (m_kind == 0 && m_known[fidx]) chk(cur_req, fetch_data, m_mem[fidx]);
  end

  task automatic bus_wr(input logic [3:0] off, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = off; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] off, input logic [31:0] exp);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = off;
    @(posedge clk); #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic fetch_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    fetch_addr = a;
    @(posedge clk); #1;
    chk(req, fetch_data, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    reg_addr = 4'h8;
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      if (reg_rdata[1:0] == 2'b00) break;
    end
  endtask

  task automatic sweep();
    for (int w = 0; w < NWORDS; w++) begin
      @(negedge clk);
      fetch_addr = 32'(w * 4);
    end
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) begin
      m_mem[i] = '0; m_known[i] = 1'b0;
    end
    // R8: reset state
    repeat (5) @(negedge clk);
    rd_chk("R8", 4'h0, 32'h0);
    rd_chk("R8", 4'h8, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R8", 4'h4, 32'h0);

    // R1: register window
    cur_req = "R1";
    bus_wr(4'h0, 32'hDEAD_BEEF);
    rd_chk("R1", 4'h0, 32'h0000_0EEF);
    bus_wr(4'h4, 32'h5A5A_A5A5);
    rd_chk("R1", 4'h4, 32'h5A5A_A5A5);
    bus_wr(4'hC, 32'h1234_5678);
    rd_chk("R1", 4'hC, 32'h0);

    // R4: erase every page with nonzero low address bits
    cur_req = "R4";
    for (int p = 0; p < 4; p++) begin
      bus_wr(4'h0, 32'(p * 1024 + 32'h2C8));
      bus_wr(4'h8, 32'hA442_0002);
      rd_chk("R5", 4'h8, 32'h2);
      wait_idle();
    end
    sweep();
    fetch_chk("R4", 32'h0000_07FC, 32'hFFFF_FFFF);

    // R3: program and AND behaviour, unaligned address
    cur_req = "R3";
    bus_wr(4'h0, 32'h0000_0406);
    bus_wr(4'h4, 32'h1234_F0F0);
    bus_wr(4'h8, 32'hA442_0001);
    wait_idle();
    fetch_chk("R3", 32'h0000_0404, 32'h1234_F0F0);
    bus_wr(4'h4, 32'hFF00_FFFF);
    bus_wr(4'h8, 32'hA442_0001);
    wait_idle();
    fetch_chk("R3", 32'h0000_0404, 32'h1200_F0F0);
    fetch_chk("R3", 32'h0000_0408, 32'hFFFF_FFFF);

    // R10: fetch masking
    fetch_chk("R10", 32'h0001_0405, 32'h1200_F0F0);

    // R2: wrong keys ignored
    cur_req = "R2";
    bus_wr(4'h0, 32'h0000_0800);
    bus_wr(4'h4, 32'h0000_0000);
    bus_wr(4'h8, 32'hA443_0001);
    rd_chk("R2", 4'h8, 32'h0);
    bus_wr(4'h8, 32'h0000_0003);
    rd_chk("R2", 4'h8, 32'h0);
    fetch_chk("R2", 32'h0000_0800, 32'hFFFF_FFFF);

    // R6: commands during busy ignored
    cur_req = "R6";
    bus_wr(4'h4, 32'h0F0F_0F0F);
    bus_wr(4'h8, 32'hA442_0001);
    bus_wr(4'h8, 32'hA442_0002);
    wait_idle();
    fetch_chk("R6", 32'h0000_0800, 32'h0F0F_0F0F);
    bus_wr(4'h0, 32'h0000_0C10);
    bus_wr(4'h4, 32'h0000_0000);
    bus_wr(4'h8, 32'hA442_0002);
    bus_wr(4'h8, 32'hA442_0001);
    rd_chk("R6", 4'h8, 32'h2);
    wait_idle();
    fetch_chk("R6", 32'h0000_0C10, 32'hFFFF_FFFF);

    // R9: operands captured at acceptance
    cur_req = "R9";
    bus_wr(4'h0, 32'h0000_0900);
    bus_wr(4'h4, 32'h00FF_00FF);
    bus_wr(4'h8, 32'hA442_0001);
    bus_wr(4'h4, 32'h0000_0000);
    bus_wr(4'h0, 32'h0000_0904);
    wait_idle();
    fetch_chk("R9", 32'h0000_0900, 32'h00FF_00FF);
    fetch_chk("R9", 32'h0000_0904, 32'hFFFF_FFFF);

    // R7: both bits select erase
    cur_req = "R7";
    bus_wr(4'h0, 32'h0000_0500);
    bus_wr(4'h4, 32'h0000_0000);
    bus_wr(4'h8, 32'hA442_0003);
    rd_chk("R7", 4'h8, 32'h2);
    wait_idle();
    fetch_chk("R7", 32'h0000_0404, 32'hFFFF_FFFF);
    fetch_chk("R4", 32'h0000_0800, 32'h0F0F_0F0F);

    cur_req = "R4";
    sweep();

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule